// File: doc/BRIEF.md
# ADC Input-Select Register with Deferred Update

This block is the control register that picks the reference and the analog input for a converter front end. It also sets how a finished result is aligned when read. Software writes one 8-bit location. The write lands in the visible register on the next clock edge. The block also drives an active copy of the reference and channel fields, and the converter uses that copy. The active copy follows the visible register only while no conversion is in flight, or at the edge where a conversion reports completion. A reconfiguration written mid-conversion therefore never disturbs the sample already being taken.

The alignment bit is not shadowed. The block latches each finished 10-bit result when the done pulse arrives and presents it as a 16-bit view. The view is padded low or high according to the alignment bit currently held in the visible register. A change of alignment therefore reformats the stored result at once, even while a conversion runs.

Top module: `adc_sel_reg`

## Requirements
- R1: After reset the register reads 0x00, both active outputs are zero, and the result view is zero.
- R2: A write with the address equal to 0x7C stores all eight data bits. The register layout is: bits 7:6 reference code, bit 5 left-align, bits 4:0 channel. A read at 0x7C returns the stored byte in the same cycle the address is applied.
- R3: A write to any other address leaves the register and the active outputs unchanged. A read at any other address returns 0x00.
- R4: With the busy input low, a write to the register appears on the active reference and channel outputs on the next clock edge.
- R5: While the busy input is high and no done pulse occurs, the active reference and channel outputs hold their value whatever is written.
- R6: On a done pulse, the active outputs take the reference and channel fields of the visible register on that clock edge.
- R7: When a register write and a done pulse share a cycle, the active outputs take the newly written fields.
- R8: A done pulse stores the raw 10-bit result. With the left-align bit zero, the view carries it in bits 9:0 and bits 15:10 are zero.
- R9: With the left-align bit one, the view carries the stored result in bits 15:6 and bits 5:0 are zero. A write to the alignment bit takes effect on the edge that stores it, even while busy.
- R10: The reference code passes to the active output unchanged for all four values: 00 external pin with the internal reference off, 01 analog supply, 10 reserved, 11 internal 1.1 V.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | 8 | Bus address |
| bus_we_i | input | 1 | Bus write enable |
| bus_wdata_i | input | 8 | Bus write data |
| bus_rdata_o | output | 8 | Bus read data |
| conv_busy_i | input | 1 | Conversion in progress |
| conv_done_i | input | 1 | One-cycle conversion-complete pulse |
| conv_raw_i | input | 10 | Raw conversion result |
| act_ref_o | output | 2 | Reference code in use by the converter |
| act_chan_o | output | 5 | Channel code in use by the converter |
| res_view_o | output | 16 | Stored result, aligned per the alignment bit |

## Verification
The assertions check a set of rules on every cycle:
- a write at the register address is captured;
- writes elsewhere are ignored;
- the active copy holds during a busy cycle without a done pulse;
- the active copy reloads on a done pulse or an idle write, with the fresh write winning a collision;
- the result view keeps its padding bits clear.

The bench scenarios cover what needs a sequence or wide data. They sweep every byte value through the register and every address past it. They also sweep every raw result under both alignments and build the mid-conversion reconfigure story, in which the old selection survives until done while the alignment changes at once.

// File: rtl/adc_sel_pkg.sv
package adc_sel_pkg;

   localparam int unsigned REF_W  = 2;
   localparam int unsigned CHAN_W = 5;
   localparam int unsigned BYTE_W = 8;

   typedef enum logic [REF_W-1:0] {
      REF_EXT_PIN = 2'b00,
      REF_SUPPLY  = 2'b01,
      REF_RSVD    = 2'b10,
      REF_INT_1V1 = 2'b11
   } ref_sel_e;

   typedef struct packed {
      logic [REF_W-1:0]  ref_sel;
      logic              left_adj;
      logic [CHAN_W-1:0] chan;
   } sel_reg_t;

endpackage

// File: rtl/adc_sel_soft.sv
module adc_sel_soft
   import adc_sel_pkg::*;
(
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic                 wr_hit_i,
   input  logic [BYTE_W-1:0]    wdata_i,
   output sel_reg_t             reg_q_o,
   output sel_reg_t             reg_next_o
);

   sel_reg_t reg_q;

   initial begin
      assert ($bits(sel_reg_t) == BYTE_W)
         else $error("register layout must fill one byte");
   end

   always_comb begin
      reg_next_o = reg_q;
      if (wr_hit_i) begin
         reg_next_o = sel_reg_t'(wdata_i);
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         reg_q <= '0;
      end else begin
         reg_q <= reg_next_o;
      end
   end

   assign reg_q_o = reg_q;

endmodule

// File: rtl/adc_sel_shadow.sv
module adc_sel_shadow
   import adc_sel_pkg::*;
(
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              busy_i,
   input  logic              done_i,
   input  sel_reg_t          reg_next_i,
   output logic [REF_W-1:0]  act_ref_o,
   output logic [CHAN_W-1:0] act_chan_o
);

   logic              load;
   logic [REF_W-1:0]  ref_q;
   logic [CHAN_W-1:0] chan_q;

   assign load = done_i | ~busy_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ref_q  <= REF_EXT_PIN;
         chan_q <= '0;
      end else if (load) begin
         ref_q  <= reg_next_i.ref_sel;
         chan_q <= reg_next_i.chan;
      end
   end

   assign act_ref_o  = ref_q;
   assign act_chan_o = chan_q;

endmodule

// File: rtl/adc_sel_result.sv
module adc_sel_result #(
   parameter int unsigned RES_W  = 10,
   parameter int unsigned VIEW_W = 16
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              done_i,
   input  logic [RES_W-1:0]  raw_i,
   input  logic              left_adj_i,
   output logic [VIEW_W-1:0] view_o
);

   localparam int unsigned PAD_W = VIEW_W - RES_W;

   initial begin
      assert (VIEW_W >= RES_W) else $error("view narrower than result");
      assert (RES_W > 0) else $error("result width must be positive");
   end

   logic [RES_W-1:0] res_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         res_q <= '0;
      end else if (done_i) begin
         res_q <= raw_i;
      end
   end

   generate
      if (PAD_W == 0) begin : g_no_pad
         logic unused_adj;
         assign unused_adj = left_adj_i;
         assign view_o     = res_q;
      end else begin : g_pad
         always_comb begin
            if (left_adj_i) begin
               view_o = {res_q, {PAD_W{1'b0}}};
            end else begin
               view_o = {{PAD_W{1'b0}}, res_q};
            end
         end
      end
   endgenerate

endmodule

// File: rtl/adc_sel_reg.sv
module adc_sel_reg
   import adc_sel_pkg::*;
#(
   parameter int unsigned    ADDR_W   = 8,
   parameter logic [7:0]     REG_ADDR = 8'h7C,
   parameter int unsigned    RES_W    = 10,
   parameter int unsigned    VIEW_W   = 16,
   parameter bit             READ_REG = 1'b0
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [ADDR_W-1:0] bus_addr_i,
   input  logic              bus_we_i,
   input  logic [BYTE_W-1:0] bus_wdata_i,
   output logic [BYTE_W-1:0] bus_rdata_o,
   input  logic              conv_busy_i,
   input  logic              conv_done_i,
   input  logic [RES_W-1:0]  conv_raw_i,
   output logic [REF_W-1:0]  act_ref_o,
   output logic [CHAN_W-1:0] act_chan_o,
   output logic [VIEW_W-1:0] res_view_o
);

   initial begin
      assert (ADDR_W >= 8) else $error("address too narrow for register offset");
   end

   logic              addr_hit;
   logic              wr_hit;
   sel_reg_t          reg_q;
   sel_reg_t          reg_next;
   logic [BYTE_W-1:0] soft_q;

   assign addr_hit = (bus_addr_i == ADDR_W'(REG_ADDR));
   assign wr_hit   = bus_we_i & addr_hit;
   assign soft_q   = reg_q;

   adc_sel_soft u_soft (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_hit_i   (wr_hit),
      .wdata_i    (bus_wdata_i),
      .reg_q_o    (reg_q),
      .reg_next_o (reg_next)
   );

   adc_sel_shadow u_shadow (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .busy_i     (conv_busy_i),
      .done_i     (conv_done_i),
      .reg_next_i (reg_next),
      .act_ref_o  (act_ref_o),
      .act_chan_o (act_chan_o)
   );

   adc_sel_result #(
      .RES_W  (RES_W),
      .VIEW_W (VIEW_W)
   ) u_result (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .done_i     (conv_done_i),
      .raw_i      (conv_raw_i),
      .left_adj_i (reg_q.left_adj),
      .view_o     (res_view_o)
   );

   generate
      if (READ_REG) begin : g_rd_reg
         logic [BYTE_W-1:0] rdata_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               rdata_q <= '0;
            end else begin
               rdata_q <= addr_hit ? soft_q : '0;
            end
         end
         assign bus_rdata_o = rdata_q;
      end else begin : g_rd_comb
         assign bus_rdata_o = addr_hit ? soft_q : '0;
      end
   endgenerate

endmodule

// File: rtl/adc_sel_chk.sv
module adc_sel_chk #(
   parameter int unsigned ADDR_W   = 8,
   parameter logic [7:0]  REG_ADDR = 8'h7C,
   parameter int unsigned RES_W    = 10,
   parameter int unsigned VIEW_W   = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] addr,
   input logic              we,
   input logic [7:0]        wdata,
   input logic              busy,
   input logic              done,
   input logic [RES_W-1:0]  raw,
   input logic [1:0]        act_ref,
   input logic [4:0]        act_ch,
   input logic [VIEW_W-1:0] view,
   input logic [7:0]        soft_q
);

   localparam int unsigned PAD_W = VIEW_W - RES_W;

   logic hit;
   assign hit = we && (addr == ADDR_W'(REG_ADDR));

   a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> soft_q == $past(wdata));

   a_r3_ignore_miss: assert property (@(posedge clk) disable iff (!rst_n)
      !hit |=> $stable(soft_q));

   a_r4_idle_load: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && !busy) |=> (act_ref == $past(wdata[7:6])) && (act_ch == $past(wdata[4:0])));

   a_r5_hold_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> $stable(act_ref) && $stable(act_ch));

   a_r6_done_load: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !hit) |=> (act_ref == $past(soft_q[7:6])) && (act_ch == $past(soft_q[4:0])));

   a_r7_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (done && hit) |=> (act_ref == $past(wdata[7:6])) && (act_ch == $past(wdata[4:0])));

   generate
      if (PAD_W > 0) begin : g_pad_chk
         a_r8_right_pad: assert property (@(posedge clk) disable iff (!rst_n)
            !soft_q[5] |-> view[VIEW_W-1 -: PAD_W] == '0);
         a_r9_left_pad: assert property (@(posedge clk) disable iff (!rst_n)
            soft_q[5] |-> view[PAD_W-1:0] == '0);
         a_r8_store: assert property (@(posedge clk) disable iff (!rst_n)
            done |=> (soft_q[5] ? view[VIEW_W-1 -: RES_W] : view[RES_W-1:0]) == $past(raw));
      end else begin : g_nopad_chk
         a_r8_store: assert property (@(posedge clk) disable iff (!rst_n)
            done |=> view == $past(raw));
      end
   endgenerate

endmodule

bind adc_sel_reg adc_sel_chk #(
   .ADDR_W   (ADDR_W),
   .REG_ADDR (REG_ADDR),
   .RES_W    (RES_W),
   .VIEW_W   (VIEW_W)
) u_chk (
   .clk     (clk_i),
   .rst_n   (rst_ni),
   .addr    (bus_addr_i),
   .we      (bus_we_i),
   .wdata   (bus_wdata_i),
   .busy    (conv_busy_i),
   .done    (conv_done_i),
   .raw     (conv_raw_i),
   .act_ref (act_ref_o),
   .act_ch  (act_chan_o),
   .view    (res_view_o),
   .soft_q  (soft_q)
);

// File: tb/adc_sel_reg_bench.sv
`timescale 1ns/1ps
module adc_sel_reg_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  addr = 8'h00;
   logic        we = 1'b0;
   logic [7:0]  wdata = 8'h00;
   logic [7:0]  rdata;
   logic        busy = 1'b0;
   logic        done = 1'b0;
   logic [9:0]  raw = '0;
   logic [1:0]  act_ref;
   logic [4:0]  act_ch;
   logic [15:0] view;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   adc_sel_reg u_adc_sel_reg (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .bus_addr_i  (addr),
      .bus_we_i    (we),
      .bus_wdata_i (wdata),
      .bus_rdata_o (rdata),
      .conv_busy_i (busy),
      .conv_done_i (done),
      .conv_raw_i  (raw),
      .act_ref_o   (act_ref),
      .act_chan_o  (act_ch),
      .res_view_o  (view)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic chk_eq(input string req, input int act, input int exp);
      chk(act == exp, req, act, exp);
   endtask

   // one bus write; returns at the negedge after the capturing edge
   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      addr = a; wdata = d; we = 1'b1;
      @(negedge clk);
      we = 1'b0; addr = 8'h7C;
   endtask

   task automatic pulse_done();
      @(negedge clk);
      done = 1'b1;
      @(negedge clk);
      done = 1'b0;
   endtask

   task automatic rd_chk(input string req, input logic [7:0] exp);
      addr = 8'h7C;
      #0.5;
      chk_eq(req, rdata, exp);
   endtask

   initial begin
      #400000;
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=hang expected=finish");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      addr = 8'h7C;
      #0.5;
      chk_eq("R1 reg", rdata, 0);
      chk_eq("R1 ref", act_ref, 0);
      chk_eq("R1 chan", act_ch, 0);
      chk_eq("R1 view", view, 0);
      @(negedge clk);
      rst_n = 1'b1;

      // R2 / R4 / R10: every byte through the register while idle
      for (int v = 0; v < 256; v++) begin
         wr(8'h7C, 8'(v));
         rd_chk("R2 readback", 8'(v));
         chk_eq("R4 idle ref", act_ref, (v >> 6) & 3);
         chk_eq("R4 idle chan", act_ch, v & 31);
      end
      for (int c = 0; c < 4; c++) begin
         wr(8'h7C, 8'(c << 6));
         chk_eq("R10 ref code", act_ref, c);
      end

      // R3: every other address ignored
      wr(8'h7C, 8'h5A);
      for (int a = 0; a < 256; a++) begin
         if (a == 8'h7C) continue;
         wr(8'(a), 8'hA5);
         addr = 8'(a);
         #0.5;
         chk_eq("R3 miss read", rdata, 0);
         rd_chk("R3 reg kept", 8'h5A);
         chk_eq("R3 ref kept", act_ref, 1);
         chk_eq("R3 chan kept", act_ch, 5'h1A);
      end

      // R5 / R6: write during busy is deferred until done
      wr(8'h7C, 8'h00);
      @(negedge clk); busy = 1'b1;
      wr(8'h7C, 8'hDF);
      rd_chk("R5 reg visible", 8'hDF);
      chk_eq("R5 ref held", act_ref, 0);
      chk_eq("R5 chan held", act_ch, 0);
      repeat (3) @(negedge clk);
      chk_eq("R5 chan still held", act_ch, 0);
      pulse_done();
      chk_eq("R6 ref loaded", act_ref, 3);
      chk_eq("R6 chan loaded", act_ch, 31);

      // R7: write and done in the same cycle
      wr(8'h7C, 8'h41);
      chk_eq("R7 pre chan held", act_ch, 31);
      @(negedge clk);
      addr = 8'h7C; wdata = 8'h8C; we = 1'b1; done = 1'b1;
      @(negedge clk);
      we = 1'b0; done = 1'b0;
      chk_eq("R7 ref new", act_ref, 2);
      chk_eq("R7 chan new", act_ch, 5'h0C);
      @(negedge clk); busy = 1'b0;

      // R8 / R9: every raw result in both alignments
      wr(8'h7C, 8'h00);
      for (int r = 0; r < 1024; r++) begin
         @(negedge clk); raw = 10'(r);
         pulse_done();
         chk_eq("R8 right view", view, r);
         wr(8'h7C, 8'h20);
         chk_eq("R9 left view", view, r << 6);
         wr(8'h7C, 8'h00);
      end

      // R9 during busy: alignment acts at once, selection held
      @(negedge clk); raw = 10'h2B7;
      pulse_done();
      @(negedge clk); busy = 1'b1;
      wr(8'h7C, 8'hE3);
      chk_eq("R9 busy left view", view, 16'h2B7 << 6);
      chk_eq("R9 busy chan held", act_ch, 0);
      busy = 1'b0;

      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule